// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a bus transceiver that supports board-level scan testing. A serial test bus made of a test clock, a mode-select line, a serial data input and a serial data output drives a sixteen-state sequencer. The level of the mode-select line at each rising test-clock edge steers the sequencer through either the instruction path or the data path. The sequencer holds an instruction register and four data registers: a one-bit bypass stage, a 32-bit identification word, a 3-bit control register that chooses the built-in test operation, and a 48-bit boundary chain. The current instruction chooses which data register sits between the serial input and the serial output.

The sequencer reaches its reset state either from an active-low asynchronous reset or from five rising edges with mode-select high. In that state the normal transceiver function is selected. The instruction becomes the identification opcode, the control register selects the signature-analysis operation, and the four output-control cells at the top of the boundary chain are set high, which keeps the port drivers in high impedance. The block raises a run flag while the sequencer sits in the idle state, and the transceiver uses that flag to run the operation named by the control register. The transceiver datapath and the test operations themselves are outside this block.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `trst_n` is low the sequencer is held in the reset state: `test_off` reads 1, `op_run` reads 0 and `tdo_oe` reads 0, with no clock edge needed.
- R2: The sequencer has sixteen states, and each next state depends only on `tms` sampled at the rising edge of `tck`. Six states hold under a repeated `tms` level: reset (`tms`=1), idle, shift-DR, pause-DR, shift-IR and pause-IR (`tms`=0). `test_off` reads 1 exactly in the reset state.
- R3: From any state, five consecutive rising edges with `tms`=1 bring the sequencer to the reset state.
- R4: In the reset state the 8-bit instruction becomes 8'b10000001 (identification). A data scan then shifts out the 32-bit identification word, least significant bit first.
- R5: In the reset state the 3-bit control register becomes 3'b010 (signature analysis), and `op_sel` shows this value.
- R6: In the reset state bits 47 to 44 of the boundary chain become 1, and bits 43 to 0 keep their contents.
- R7: `op_run` is 1 exactly while the sequencer is in the idle state.
- R8: Capture-IR loads 8'b00000001 into the instruction shift stage, which then shifts out least significant bit first. A shifted opcode takes effect only on the edge that leaves Update-IR.
- R9: Opcode 8'hFF, and any opcode other than 8'h81, 8'h82 and 8'h87, selects the one-bit bypass stage. The stage captures 0 and delays the serial input by one clock.
- R10: Capture-DR loads the selected register. Opcode 8'h82 selects the boundary chain, which captures `bsr_pin_in`. Opcode 8'h87 selects the control register, which captures its current value. A control value shifted in reaches `op_sel` only on the edge that leaves Update-DR.
- R11: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 exactly for the falling edges that occur in shift-IR or shift-DR.
- R12: Select-DR and Select-IR perform no action and are always left on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset of the test logic |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data into the selected register |
| bsr_pin_in | input | 48 | Pin values that the boundary chain captures |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Serial output enable, high while shifting |
| test_off | output | 1 | High in the reset state: normal transceiver function |
| op_run | output | 1 | High in the idle state: run the selected test operation |
| op_sel | output | 3 | Control register value that names the test operation |
| bsr_q | output | 48 | Boundary chain contents |

## Verification
The bench sweeps every 8-step mode-select pattern from the reset state and compares each step with its own sixteen-state model. A wrong transition, a select state that lingers, or a return path longer than five edges shows up there as a mismatched `test_off`, `op_run` or `tdo_oe`. Scan tests go after the capture values and the one-bit delay of bypass for an unknown opcode. A design that captured the wrong constant, or sent unknown codes to a wider register, would shift out a misaligned stream. The control register is read just before and just after Update-DR to catch an early update. The boundary chain is filled with a pattern, and a return to reset must set only the top four cells. A mid-shift asynchronous reset must restore the identification instruction and the default control value.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

   typedef enum logic [3:0] {
      TS_RESET,  TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_t;

   typedef enum logic [1:0] {
      DSEL_BYPASS,
      DSEL_IDENT,
      DSEL_BSCAN,
      DSEL_BCTL
   } dsel_t;

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state,
   output logic       in_reset,
   output logic       in_idle,
   output logic       cap_dr,
   output logic       shf_dr,
   output logic       upd_dr,
   output logic       cap_ir,
   output logic       shf_ir,
   output logic       upd_ir
);

   tap_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_RESET;
      else         state <= nxt;
   end

   assign in_reset = (state == TS_RESET);
   assign in_idle  = (state == TS_IDLE);
   assign cap_dr   = (state == TS_CAP_DR);
   assign shf_dr   = (state == TS_SHF_DR);
   assign upd_dr   = (state == TS_UPD_DR);
   assign cap_ir   = (state == TS_CAP_IR);
   assign shf_ir   = (state == TS_SHF_IR);
   assign upd_ir   = (state == TS_UPD_IR);

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
   import scan_tap_pkg::*;
#(
   parameter int              IR_W      = 8,
   parameter logic [IR_W-1:0] IR_RST    = 8'h81,
   parameter logic [IR_W-1:0] OP_IDCODE = 8'h81,
   parameter logic [IR_W-1:0] OP_BSCAN  = 8'h82,
   parameter logic [IR_W-1:0] OP_BCTL   = 8'h87,
   parameter logic [IR_W-1:0] OP_BYPASS = 8'hFF
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  logic            in_reset,
   input  logic            cap_ir,
   input  logic            shf_ir,
   input  logic            upd_ir,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so,
   output dsel_t           dsel
);

   localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= IR_RST;
         ir_q  <= IR_RST;
      end else if (in_reset) begin
         ir_sh <= IR_RST;
         ir_q  <= IR_RST;
      end else begin
         if (cap_ir)      ir_sh <= IR_CAPT;
         else if (shf_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
         if (upd_ir)      ir_q  <= ir_sh;
      end
   end

   assign ir_so = ir_sh[0];

   always_comb begin
      if (ir_q == OP_IDCODE)      dsel = DSEL_IDENT;
      else if (ir_q == OP_BSCAN)  dsel = DSEL_BSCAN;
      else if (ir_q == OP_BCTL)   dsel = DSEL_BCTL;
      else if (ir_q == OP_BYPASS) dsel = DSEL_BYPASS;
      else                        dsel = DSEL_BYPASS;
   end

endmodule

// File: rtl/scan_tap_dregs.sv
`timescale 1ns/1ps
module scan_tap_dregs
   import scan_tap_pkg::*;
#(
   parameter int               ID_W       = 32,
   parameter logic [ID_W-1:0]  ID_VAL     = 32'h0B5A_C02F,
   parameter int               BCR_W      = 3,
   parameter logic [BCR_W-1:0] BCR_RST    = 3'b010,
   parameter int               BSR_W      = 48,
   parameter int               OUTCTL_LSB = 44
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tdi,
   input  logic             in_reset,
   input  logic             cap_dr,
   input  logic             shf_dr,
   input  logic             upd_dr,
   input  dsel_t            dsel,
   input  logic [BSR_W-1:0] bsr_pin_in,
   output logic             dr_so,
   output logic [BCR_W-1:0] bcr_q,
   output logic [BSR_W-1:0] bsr_q
);

   logic sel_byp, sel_id, sel_bsr, sel_bcr;
   assign sel_byp = (dsel == DSEL_BYPASS);
   assign sel_id  = (dsel == DSEL_IDENT);
   assign sel_bsr = (dsel == DSEL_BSCAN);
   assign sel_bcr = (dsel == DSEL_BCTL);

   // one-bit bypass stage
   logic byp_q;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_q <= 1'b0;
      else if (cap_dr && sel_byp) byp_q <= 1'b0;
      else if (shf_dr && sel_byp) byp_q <= tdi;
   end

   // identification word
   logic [ID_W-1:0] id_sh;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)               id_sh <= ID_VAL;
      else if (cap_dr && sel_id) id_sh <= ID_VAL;
      else if (shf_dr && sel_id) id_sh <= {tdi, id_sh[ID_W-1:1]};
   end

   // test-operation control register: shift stage plus applied value
   logic [BCR_W-1:0] bcr_sh;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         bcr_sh <= BCR_RST;
         bcr_q  <= BCR_RST;
      end else if (in_reset) begin
         bcr_sh <= BCR_RST;
         bcr_q  <= BCR_RST;
      end else begin
         if (cap_dr && sel_bcr)      bcr_sh <= bcr_q;
         else if (shf_dr && sel_bcr) bcr_sh <= {tdi, bcr_sh[BCR_W-1:1]};
         if (upd_dr && sel_bcr)      bcr_q  <= bcr_sh;
      end
   end

   // boundary chain: control cells reset high, data cells keep their contents
   logic [BSR_W:0] chain;
   assign chain = {tdi, bsr_q};

   for (genvar i = 0; i < BSR_W; i++) begin : g_cell
      logic cell_q;
      if (i >= OUTCTL_LSB) begin : g_ctl
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                 cell_q <= 1'b1;
            else if (in_reset)           cell_q <= 1'b1;
            else if (cap_dr && sel_bsr)  cell_q <= bsr_pin_in[i];
            else if (shf_dr && sel_bsr)  cell_q <= chain[i+1];
         end
      end else begin : g_dat
         always_ff @(posedge tck) begin
            if (!in_reset) begin
               if (cap_dr && sel_bsr)      cell_q <= bsr_pin_in[i];
               else if (shf_dr && sel_bsr) cell_q <= chain[i+1];
            end
         end
      end
      assign bsr_q[i] = cell_q;
   end

   always_comb begin
      unique case (dsel)
         DSEL_IDENT:  dr_so = id_sh[0];
         DSEL_BSCAN:  dr_so = bsr_q[0];
         DSEL_BCTL:   dr_so = bcr_sh[0];
         default:     dr_so = byp_q;
      endcase
   end

endmodule

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
   import scan_tap_pkg::*;
#(
   parameter int               IR_W       = 8,
   parameter logic [IR_W-1:0]  IR_RST     = 8'h81,
   parameter logic [IR_W-1:0]  OP_IDCODE  = 8'h81,
   parameter logic [IR_W-1:0]  OP_BSCAN   = 8'h82,
   parameter logic [IR_W-1:0]  OP_BCTL    = 8'h87,
   parameter logic [IR_W-1:0]  OP_BYPASS  = 8'hFF,
   parameter int               ID_W       = 32,
   parameter logic [ID_W-1:0]  ID_VAL     = 32'h0B5A_C02F,
   parameter int               BCR_W      = 3,
   parameter logic [BCR_W-1:0] BCR_RST    = 3'b010,
   parameter int               BSR_W      = 48,
   parameter int               OUTCTL_LSB = 44
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   input  logic [BSR_W-1:0] bsr_pin_in,
   output logic             tdo,
   output logic             tdo_oe,
   output logic             test_off,
   output logic             op_run,
   output logic [BCR_W-1:0] op_sel,
   output logic [BSR_W-1:0] bsr_q
);

   if (IR_W < 2) begin : g_bad_ir
      $error("scan_tap_ctrl: IR_W must be at least 2");
   end
   if (ID_W < 1 || BCR_W < 1) begin : g_bad_w
      $error("scan_tap_ctrl: register widths must be positive");
   end
   if (OUTCTL_LSB < 0 || OUTCTL_LSB >= BSR_W) begin : g_bad_bsr
      $error("scan_tap_ctrl: OUTCTL_LSB must lie inside the boundary chain");
   end

   tap_state_t      state;
   logic            in_reset, in_idle;
   logic            cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
   logic [IR_W-1:0] ir_q;
   logic            ir_so, dr_so;
   dsel_t           dsel;
   logic [BCR_W-1:0] bcr_q;

   scan_tap_fsm u_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
      .in_reset(in_reset), .in_idle(in_idle),
      .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
      .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir)
   );

   scan_tap_ir #(
      .IR_W(IR_W), .IR_RST(IR_RST), .OP_IDCODE(OP_IDCODE),
      .OP_BSCAN(OP_BSCAN), .OP_BCTL(OP_BCTL), .OP_BYPASS(OP_BYPASS)
   ) u_ir (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
      .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
      .ir_q(ir_q), .ir_so(ir_so), .dsel(dsel)
   );

   scan_tap_dregs #(
      .ID_W(ID_W), .ID_VAL(ID_VAL), .BCR_W(BCR_W), .BCR_RST(BCR_RST),
      .BSR_W(BSR_W), .OUTCTL_LSB(OUTCTL_LSB)
   ) u_dregs (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
      .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr), .dsel(dsel),
      .bsr_pin_in(bsr_pin_in), .dr_so(dr_so), .bcr_q(bcr_q), .bsr_q(bsr_q)
   );

   // serial output retimed to the falling edge
   logic tdo_r, oe_r;
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_r <= 1'b0;
         oe_r  <= 1'b0;
      end else begin
         oe_r  <= shf_dr | shf_ir;
         tdo_r <= shf_ir ? ir_so : dr_so;
      end
   end

   assign tdo      = tdo_r;
   assign tdo_oe   = oe_r;
   assign test_off = in_reset;
   assign op_run   = in_idle;
   assign op_sel   = bcr_q;

endmodule

// File: rtl/scan_tap_ctrl_chk.sv
`timescale 1ns/1ps
module scan_tap_ctrl_chk
   import scan_tap_pkg::*;
#(
   parameter int               IR_W       = 8,
   parameter logic [IR_W-1:0]  IR_RST     = 8'h81,
   parameter int               BCR_W      = 3,
   parameter logic [BCR_W-1:0] BCR_RST    = 3'b010,
   parameter int               BSR_W      = 48,
   parameter int               OUTCTL_LSB = 44
) (
   input logic             tck,
   input logic             trst_n,
   input logic             tms,
   input tap_state_t       state,
   input logic [IR_W-1:0]  ir_q,
   input logic [BCR_W-1:0] op_sel,
   input logic [BSR_W-1:0] bsr_q,
   input logic             op_run,
   input logic             tdo_oe
);

   logic [2:0] high_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)    high_run <= '0;
      else if (!tms)  high_run <= '0;
      else if (high_run != 3'd7) high_run <= high_run + 3'd1;
   end

   // R3
   five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (high_run >= 3'd5) |-> (state == TS_RESET));

   // R12
   select_dr_leave_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_SEL_DR) |=> (state == TS_CAP_DR || state == TS_SEL_IR));

   // R12
   select_ir_leave_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_SEL_IR) |=> (state == TS_CAP_IR || state == TS_RESET));

   // R4 R5
   reset_regs_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET) |=> (ir_q == IR_RST && op_sel == BCR_RST));

   // R6
   outctl_high_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET) |=> (&bsr_q[BSR_W-1:OUTCTL_LSB]));

   // R7
   run_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(op_run) |-> ($past(state) == TS_RESET || $past(state) == TS_UPD_DR
                         || $past(state) == TS_UPD_IR));

   // R8
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_q));

   // R11
   tdo_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (state == TS_SHF_DR || state == TS_SHF_IR));

endmodule

bind scan_tap_ctrl scan_tap_ctrl_chk #(
   .IR_W(IR_W), .IR_RST(IR_RST), .BCR_W(BCR_W), .BCR_RST(BCR_RST),
   .BSR_W(BSR_W), .OUTCTL_LSB(OUTCTL_LSB)
) u_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_q(ir_q),
   .op_sel(op_sel), .bsr_q(bsr_q), .op_run(op_run), .tdo_oe(tdo_oe)
);

// File: tb/scan_tap_ctrl_test.sv
`timescale 1ns/1ps
module scan_tap_ctrl_test;

   localparam logic [31:0] ID_WORD = 32'h0B5A_C02F;

   // bench-side state numbering
   localparam int M_TLR = 0,  M_RTI = 1,  M_SDS = 2,  M_CDR = 3,  M_SDR = 4,  M_E1D = 5,
                  M_PDR = 6,  M_E2D = 7,  M_UDR = 8,  M_SIS = 9,  M_CIR = 10, M_SIR = 11,
                  M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

   logic        tck = 1'b0;
   logic        trst_n, tms, tdi;
   logic [47:0] pins;
   logic        tdo, tdo_oe, test_off, op_run;
   logic [2:0]  op_sel;
   logic [47:0] bsr_q;

   int checks = 0;
   int errors = 0;
   int ms;

   always #2.5 tck = ~tck;

   scan_tap_ctrl uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_pin_in(pins),
      .tdo(tdo), .tdo_oe(tdo_oe), .test_off(test_off), .op_run(op_run),
      .op_sel(op_sel), .bsr_q(bsr_q)
   );

   function automatic int ref_next(input int s, input bit m);
      case (s)
         M_TLR: return m ? M_TLR : M_RTI;
         M_RTI: return m ? M_SDS : M_RTI;
         M_SDS: return m ? M_SIS : M_CDR;
         M_CDR: return m ? M_E1D : M_SDR;
         M_SDR: return m ? M_E1D : M_SDR;
         M_E1D: return m ? M_UDR : M_PDR;
         M_PDR: return m ? M_E2D : M_PDR;
         M_E2D: return m ? M_UDR : M_SDR;
         M_UDR: return m ? M_SDS : M_RTI;
         M_SIS: return m ? M_TLR : M_CIR;
         M_CIR: return m ? M_E1I : M_SIR;
         M_SIR: return m ? M_E1I : M_SIR;
         M_E1I: return m ? M_UIR : M_PIR;
         M_PIR: return m ? M_E2I : M_PIR;
         M_E2I: return m ? M_UIR : M_SIR;
         default: return m ? M_SDS : M_RTI;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input bit m, input bit d, output bit o);
      bit sh;
      @(negedge tck); #1;
      o  = tdo;
      sh = (ms == M_SDR || ms == M_SIR);
      chk(tdo_oe == sh, "R11 tdo_oe", 64'(tdo_oe), 64'(sh));
      tms = m;
      tdi = d;
      @(posedge tck);
      ms = ref_next(ms, m);
      #1;
      chk(test_off == (ms == M_TLR), "R2/R12 test_off", 64'(test_off), 64'(ms == M_TLR));
      chk(op_run == (ms == M_RTI), "R7 op_run", 64'(op_run), 64'(ms == M_RTI));
   endtask

   task automatic go_idle();
      bit o;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
   endtask

   task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap);
      bit o;
      step(1'b1, 1'b0, o);
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      step(1'b0, 1'b0, o);
      for (int i = 0; i < 8; i++) begin
         step(i == 7, op[i], o);
         cap[i] = o;
      end
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
   endtask

   task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
      bit o;
      dout = '0;
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      step(1'b0, 1'b0, o);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], o);
         dout[i] = o;
      end
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0]  cap;
      logic [63:0] dout;
      logic [47:0] pat;
      bit o;
      trst_n = 1'b0;
      tms    = 1'b1;
      tdi    = 1'b0;
      pins   = '0;
      ms     = M_TLR;
      repeat (3) @(posedge tck);
      @(negedge tck); #1;
      // R1 reset state
      chk(test_off == 1'b1, "R1 test_off", 64'(test_off), 64'd1);
      chk(op_run == 1'b0, "R1 op_run", 64'(op_run), 64'd0);
      chk(tdo_oe == 1'b0, "R1 tdo_oe", 64'(tdo_oe), 64'd0);
      chk(op_sel == 3'b010, "R5 op_sel", 64'(op_sel), 64'd2);
      chk(bsr_q[47:44] == 4'hF, "R6 outctl", 64'(bsr_q[47:44]), 64'hF);
      trst_n = 1'b1;

      // R2 R12 R3: every 8-step pattern from reset, then five highs
      for (int p = 0; p < 256; p++) begin
         for (int k = 0; k < 8; k++) step(p[k], 1'b0, o);
         for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o);
         chk(test_off == 1'b1 && ms == M_TLR, "R3 five highs", 64'(test_off), 64'd1);
      end

      // R4 identification selected by default
      go_idle();
      dr_scan(32, 64'h0, dout);
      chk(dout[31:0] == ID_WORD, "R4 id word", dout, 64'(ID_WORD));

      // R8 capture value of instruction stage
      ir_scan(8'hFF, cap);
      chk(cap == 8'b0000_0001, "R8 ir capture", 64'(cap), 64'd1);

      // R9 bypass delays by one
      dr_scan(8, 64'hB3, dout);
      chk(dout[7:0] == 8'h66, "R9 bypass", dout, 64'h66);

      // R9 unknown opcode behaves as bypass
      ir_scan(8'h3C, cap);
      dr_scan(8, 64'h5D, dout);
      chk(dout[7:0] == 8'hBA, "R9 unknown opcode", dout, 64'hBA);

      // R10 control register: capture, late update
      ir_scan(8'h87, cap);
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      step(1'b0, 1'b0, o);
      for (int i = 0; i < 3; i++) begin
         step(i == 2, 3'b101 >> i, o);
         dout[i] = o;
      end
      chk(dout[2:0] == 3'b010, "R10 bcr capture", 64'(dout[2:0]), 64'd2);
      chk(op_sel == 3'b010, "R10 op_sel before update", 64'(op_sel), 64'd2);
      step(1'b1, 1'b0, o);
      chk(op_sel == 3'b010, "R10 op_sel in update", 64'(op_sel), 64'd2);
      step(1'b0, 1'b0, o);
      chk(op_sel == 3'b101, "R10 op_sel after update", 64'(op_sel), 64'd5);
      chk(op_run == 1'b1, "R7 run in idle", 64'(op_run), 64'd1);

      // R10 boundary chain capture and shift
      pins = 48'hA5C3_0F96_1E78;
      pat  = 48'h0123_4567_89AB;
      ir_scan(8'h82, cap);
      dr_scan(48, 64'(pat), dout);
      chk(dout[47:0] == pins, "R10 bsr capture", dout, 64'(pins));
      chk(bsr_q == pat, "R10 bsr shifted", 64'(bsr_q), 64'(pat));

      // R6 R5 return to reset: only the top four cells change
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, o);
      chk(bsr_q == {4'hF, pat[43:0]}, "R6 bsr reset", 64'(bsr_q), 64'({4'hF, pat[43:0]}));
      chk(op_sel == 3'b010, "R5 op_sel reset", 64'(op_sel), 64'd2);

      // R1 R4 R5 asynchronous reset in the middle of a shift
      go_idle();
      ir_scan(8'h87, cap);
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      step(1'b0, 1'b0, o);
      for (int i = 0; i < 3; i++) step(i == 2, 1'b1, o);
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      chk(op_sel == 3'b111, "R10 op_sel loaded", 64'(op_sel), 64'd7);
      step(1'b1, 1'b0, o);
      step(1'b0, 1'b0, o);
      step(1'b0, 1'b0, o);
      @(negedge tck); #1;
      trst_n = 1'b0;
      tms    = 1'b1;
      #0.5;
      chk(test_off == 1'b1, "R1 async test_off", 64'(test_off), 64'd1);
      chk(tdo_oe == 1'b0, "R1 async tdo_oe", 64'(tdo_oe), 64'd0);
      chk(op_sel == 3'b010, "R5 async op_sel", 64'(op_sel), 64'd2);
      @(posedge tck);
      @(negedge tck); #1;
      trst_n = 1'b1;
      ms = M_TLR;
      go_idle();
      dr_scan(32, 64'h0, dout);
      chk(dout[31:0] == ID_WORD, "R4 id after async reset", dout, 64'(ID_WORD));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule